// File: doc/BRIEF.md
# Period-Match Interval Timer with Postscaler

This block is an 8-bit up-counter advanced by an internal timebase tick through a selectable prescaler. The running count is compared every increment against a programmable period value. On the increment that follows a match, the count returns to zero rather than advancing. Each such return emits a single-cycle pulse that other blocks can use as a timebase, for example a baud-rate or modulation period reference.

The same pulses feed a postscaler that divides them by any integer from 1 to 16. Each postscaler terminal count sets a sticky interrupt flag. Software programs and observes the block through a small register port: the count, the period, a control byte (enable, prescale and postscale selection), and the flag.

Top module: `period_tick_timer`

## Requirements
- R1: After reset the count reads 0, the period reads 8'hFF, the control byte reads 0, the flag is low and the period pulse is low.
- R2: Register addresses are 0 = count (read/write), 1 = period (read/write), 2 = control (bit 0 enable, bits 2:1 prescale select, bits 6:3 postscale ratio minus one, bit 7 reads 0), and 3 = flag (bit 0 reads the flag, and writing 1 to bit 0 clears it). A write lands on the rising edge where bus_wr_i is high, and reads are combinational.
- R3: With the enable bit set, the count advances once every 1, 4 or 16 cycles in which tick_i is high, for prescale select 0, 1 or 2 respectively. Select 3 also divides by 16. The count does not advance in cycles where tick_i is low.
- R4: With tick_i held high, the count runs 0..P and then returns to 0, so successive period pulses are spaced prescale×(P+1) cycles apart, where P is the period value.
- R5: period_pulse_o is high for exactly the one cycle in which the count first reads 0 after a period match.
- R6: The flag is set on every (N+1)-th period pulse, where N is the postscale field, so that with tick_i high the spacing between flag sets is prescale×(P+1)×(N+1) cycles.
- R7: Once set, the flag stays high until software clears it. If a set and a clear occur in the same cycle, the set wins.
- R8: With the enable bit clear, the count holds its value and no period pulse is produced.
- R9: A write to the count or to the control register restarts the prescaler and postscaler progress. A count write takes priority over an increment in the same cycle.
- R10: A count written above the period value advances to 8'hFF and wraps to 0 without a period pulse, and then matches at the period value as usual.
- R11: A new period value is used at the very next comparison.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| tick_i | input | 1 | Internal timebase tick (clock enable for the prescaler) |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | 2 | Register address for reads and writes |
| bus_wdata_i | input | 8 | Register write data |
| bus_rdata_o | output | 8 | Register read data |
| period_pulse_o | output | 1 | One-cycle pulse at each period wrap |
| irq_flag_o | output | 1 | Sticky interrupt flag set by the postscaler |

## Verification
The main function is exercised with six combinations of prescale, period and postscale. These include period 0 at divide 16, a divide-by-1 setting with period 249 and postscale 16, and odd postscale ratios such as 3, 5 and 7. Measuring both the pulse spacing and the flag spacing for each combination separates errors in the prescale decode, the off-by-one of the period match, and the non-power-of-two postscale count. Directed cases then cover:
- a count written above the period, which separates a natural overflow from a match;
- a period shrunk mid-run;
- a count write landing partway through a prescale interval;
- a gated tick, a disabled timer, and the stickiness of the flag.

// File: rtl/ptt_pkg.sv
package ptt_pkg;
  localparam int unsigned CNT_W  = 8;
  localparam int unsigned ADDR_W = 2;
  localparam int unsigned PSEL_W = 2;
  localparam int unsigned POST_W = 4;

  localparam logic [ADDR_W-1:0] ADDR_COUNT  = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_PERIOD = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_CTRL   = 2'd2;
  localparam logic [ADDR_W-1:0] ADDR_FLAG   = 2'd3;

  typedef struct packed {
    logic [POST_W-1:0] post_m1;
    logic [PSEL_W-1:0] pre_sel;
    logic              run;
  } ctrl_t;
endpackage

// File: rtl/ptt_prescaler.sv
module ptt_prescaler #(
  parameter int unsigned SEL_W = 2,
  parameter int unsigned DIV_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic             tick_i,
  input  logic             clr_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             inc_o
);
  localparam logic [DIV_W-1:0] LIM_DIV4  = DIV_W'(3);
  localparam logic [DIV_W-1:0] LIM_DIV16 = DIV_W'(15);

  logic [DIV_W-1:0] pre_q, pre_d;
  logic [DIV_W-1:0] lim;
  logic             step;

  always_comb begin
    case (sel_i)
      SEL_W'(0): lim = '0;
      SEL_W'(1): lim = LIM_DIV4;
      default:   lim = LIM_DIV16;
    endcase
  end

  assign step  = run_i && tick_i && !clr_i;
  assign inc_o = step && (pre_q == lim);

  always_comb begin
    pre_d = pre_q;
    if (clr_i)      pre_d = '0;
    else if (inc_o) pre_d = '0;
    else if (step)  pre_d = pre_q + DIV_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end

  // R3: an increment only ever comes from an enabled, ticking cycle
  a_r3_inc_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
    inc_o |-> (run_i && tick_i));
endmodule

// File: rtl/ptt_count_core.sv
module ptt_count_core #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc_i,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic [W-1:0] period_i,
  output logic [W-1:0] cnt_o,
  output logic         match_o,
  output logic         pulse_o
);
  localparam logic [W-1:0] CNT_MAX = '1;

  logic [W-1:0] cnt_q, cnt_d;
  logic         pulse_q, pulse_d;
  logic         hit;

  assign hit     = (cnt_q == period_i);
  assign match_o = inc_i && !load_i && hit;

  always_comb begin
    cnt_d   = cnt_q;
    pulse_d = 1'b0;
    if (load_i) begin
      cnt_d = load_val_i;
    end else if (inc_i) begin
      if (hit) begin
        cnt_d   = '0;
        pulse_d = 1'b1;
      end else begin
        cnt_d = cnt_q + W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      pulse_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      pulse_q <= pulse_d;
    end
  end

  assign cnt_o   = cnt_q;
  assign pulse_o = pulse_q;

  // R5: a pulse is only visible while the count reads zero
  a_r5_pulse_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_q |-> (cnt_q == '0));

  // R8: without an increment or a load the count holds and no pulse follows
  a_r8_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc_i && !load_i) |=> ($stable(cnt_q) && !pulse_q));

  // R10: a natural overflow past the top value is not a period match
  a_r10_overflow_no_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_i && !load_i && cnt_q == CNT_MAX && period_i != CNT_MAX)
      |=> (cnt_q == '0 && !pulse_q));
endmodule

// File: rtl/ptt_postscaler.sv
module ptt_postscaler #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         match_i,
  input  logic         clr_i,
  input  logic [W-1:0] ratio_m1_i,
  output logic         fire_o
);
  logic [W-1:0] pc_q, pc_d;

  assign fire_o = match_i && !clr_i && (pc_q == ratio_m1_i);

  always_comb begin
    pc_d = pc_q;
    if (clr_i)        pc_d = '0;
    else if (fire_o)  pc_d = '0;
    else if (match_i) pc_d = pc_q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc_q <= '0;
    else        pc_q <= pc_d;
  end

  // R6: the match counter never runs past the selected ratio
  a_r6_count_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_q <= ratio_m1_i));
endmodule

// File: rtl/period_tick_timer.sv
module period_tick_timer
  import ptt_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick_i,
  input  logic        bus_wr_i,
  input  logic [1:0]  bus_addr_i,
  input  logic [7:0]  bus_wdata_i,
  output logic [7:0]  bus_rdata_o,
  output logic        period_pulse_o,
  output logic        irq_flag_o
);
  localparam int unsigned CTRL_W  = $bits(ctrl_t);
  localparam int unsigned PDIV_W  = 4;
  localparam logic [CNT_W-1:0] PERIOD_RST = '1;

  ctrl_t            ctrl_q, ctrl_d;
  logic [CNT_W-1:0] period_q, period_d;
  logic             flag_q, flag_d;

  logic wr_count, wr_period, wr_ctrl, wr_flag;
  logic restart;
  logic inc;
  logic match;
  logic fire;
  logic [CNT_W-1:0] cnt;

  assign wr_count  = bus_wr_i && (bus_addr_i == ADDR_COUNT);
  assign wr_period = bus_wr_i && (bus_addr_i == ADDR_PERIOD);
  assign wr_ctrl   = bus_wr_i && (bus_addr_i == ADDR_CTRL);
  assign wr_flag   = bus_wr_i && (bus_addr_i == ADDR_FLAG);
  assign restart   = wr_count || wr_ctrl;

  always_comb begin
    ctrl_d   = ctrl_q;
    period_d = period_q;
    flag_d   = flag_q;
    if (wr_ctrl)   ctrl_d   = ctrl_t'(bus_wdata_i[CTRL_W-1:0]);
    if (wr_period) period_d = bus_wdata_i;
    if (fire)                          flag_d = 1'b1;
    else if (wr_flag && bus_wdata_i[0]) flag_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      period_q <= PERIOD_RST;
      flag_q   <= 1'b0;
    end else begin
      ctrl_q   <= ctrl_d;
      period_q <= period_d;
      flag_q   <= flag_d;
    end
  end

  ptt_prescaler #(.SEL_W(PSEL_W), .DIV_W(PDIV_W)) u_pre (
    .clk    (clk),
    .rst_n  (rst_n),
    .run_i  (ctrl_q.run),
    .tick_i (tick_i),
    .clr_i  (restart),
    .sel_i  (ctrl_q.pre_sel),
    .inc_o  (inc)
  );

  ptt_count_core #(.W(CNT_W)) u_core (
    .clk        (clk),
    .rst_n      (rst_n),
    .inc_i      (inc),
    .load_i     (wr_count),
    .load_val_i (bus_wdata_i),
    .period_i   (period_q),
    .cnt_o      (cnt),
    .match_o    (match),
    .pulse_o    (period_pulse_o)
  );

  ptt_postscaler #(.W(POST_W)) u_post (
    .clk        (clk),
    .rst_n      (rst_n),
    .match_i    (match),
    .clr_i      (restart),
    .ratio_m1_i (ctrl_q.post_m1),
    .fire_o     (fire)
  );

  always_comb begin
    case (bus_addr_i)
      ADDR_COUNT:  bus_rdata_o = cnt;
      ADDR_PERIOD: bus_rdata_o = period_q;
      ADDR_CTRL:   bus_rdata_o = 8'(ctrl_q);
      default:     bus_rdata_o = {7'd0, flag_q};
    endcase
  end

  assign irq_flag_o = flag_q;

  // R7: a postscaler terminal count always leaves the flag set
  a_r7_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> irq_flag_o);

  // R7: the flag only drops after a clear write
  a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_flag_o && !(wr_flag && bus_wdata_i[0])) |=> irq_flag_o);
endmodule

// File: tb/period_tick_timer_tb.sv
`timescale 1ns/1ps
module period_tick_timer_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       tick;
  logic       wr;
  logic [1:0] addr;
  logic [7:0] wdata;
  logic [7:0] rdata;
  logic       pulse;
  logic       irq;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  period_tick_timer dut_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .tick_i         (tick),
    .bus_wr_i       (wr),
    .bus_addr_i     (addr),
    .bus_wdata_i    (wdata),
    .bus_rdata_o    (rdata),
    .period_pulse_o (pulse),
    .irq_flag_o     (irq)
  );

  // vector: prescale select, period, postscale-1, pulse spacing, flag spacing
  localparam int NV = 6;
  localparam int VEC [NV][5] = '{
    '{0,   9,  0,  10,   10},
    '{1,   4,  2,  20,   60},
    '{2,   2,  4,  48,  240},
    '{3,   0, 15,  16,  256},
    '{0, 249, 15, 250, 4000},
    '{1,   6,  6,  28,  196}
  };

  task automatic check(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [1:0] a, input logic [7:0] d);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic reg_rd(input logic [1:0] a, output int v);
    addr = a;
    #0.5;
    v = int'(rdata);
  endtask

  task automatic wait_pulse(output int ok);
    ok = 0;
    for (int i = 0; i < 20000; i++) begin
      if (pulse) begin ok = 1; break; end
      @(negedge clk);
    end
  endtask

  initial begin
    int v, ok, k;
    rst_n = 1'b0; tick = 1'b1; wr = 1'b0; addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    reg_rd(2'd0, v); check("R1 count", v, 0);
    reg_rd(2'd1, v); check("R1 period", v, 255);
    reg_rd(2'd2, v); check("R1 control", v, 0);
    check("R1 flag", int'(irq), 0);
    check("R1 pulse", int'(pulse), 0);

    // R2: readback, bit 7 of control reads zero
    reg_wr(2'd1, 8'h5A); reg_rd(2'd1, v); check("R2 period readback", v, 8'h5A);
    reg_wr(2'd2, 8'hF6); reg_rd(2'd2, v); check("R2 control readback", v, 8'h76);
    reg_wr(2'd2, 8'h00);

    // R4 / R6: table walk
    for (int j = 0; j < NV; j++) begin
      reg_wr(2'd1, 8'(VEC[j][1]));
      reg_wr(2'd2, 8'(1 | (VEC[j][0] << 1) | (VEC[j][2] << 3)));
      reg_wr(2'd0, 8'd0);
      reg_wr(2'd3, 8'd1);
      wait_pulse(ok);
      check("R4 first pulse seen", ok, 1);
      k = 0;
      for (int i = 1; i < 20000; i++) begin
        @(negedge clk);
        if (pulse) begin k = i; break; end
      end
      check("R4 pulse spacing", k, VEC[j][3]);
      for (int i = 0; i < 20000 && !irq; i++) @(negedge clk);
      wr = 1'b1; addr = 2'd3; wdata = 8'd1;
      k = 0;
      for (int i = 1; i < 20000; i++) begin
        @(negedge clk);
        wr = 1'b0;
        if (irq) begin k = i; break; end
      end
      check("R6 flag spacing", k, VEC[j][4]);
    end

    // R5: pulse lasts one cycle (period 9, divide 1)
    reg_wr(2'd1, 8'd9);
    reg_wr(2'd2, 8'h01);
    wait_pulse(ok);
    @(negedge clk);
    check("R5 pulse one cycle", int'(pulse), 0);

    // R7: flag sticky while timer stopped, then cleared
    for (int i = 0; i < 100 && !irq; i++) @(negedge clk);
    reg_wr(2'd2, 8'h00);
    repeat (10) @(negedge clk);
    check("R7 flag sticky", int'(irq), 1);
    reg_wr(2'd3, 8'd1);
    check("R7 flag cleared", int'(irq), 0);

    // R8: disabled timer holds
    reg_wr(2'd0, 8'd4);
    ok = 0;
    for (int i = 0; i < 20; i++) begin @(negedge clk); if (pulse) ok = 1; end
    reg_rd(2'd0, v); check("R8 count held", v, 4);
    check("R8 no pulse", ok, 0);

    // R3: gated tick holds the count
    reg_wr(2'd2, 8'h01);
    tick = 1'b0;
    repeat (10) @(negedge clk);
    reg_rd(2'd0, v); check("R3 no advance without tick", v, 4);
    tick = 1'b1;

    // R9: count write restarts prescaler (divide 4, period 9)
    reg_wr(2'd2, 8'h03);
    repeat (2) @(negedge clk);
    reg_wr(2'd0, 8'd3);
    repeat (3) @(negedge clk);
    reg_rd(2'd0, v); check("R9 no early increment", v, 3);
    @(negedge clk);
    reg_rd(2'd0, v); check("R9 increment after full interval", v, 4);

    // R10: count above period
    reg_wr(2'd1, 8'd5);
    reg_wr(2'd2, 8'h01);
    reg_wr(2'd0, 8'd250);
    ok = 0;
    for (int i = 0; i < 6; i++) begin @(negedge clk); if (pulse) ok = 1; end
    reg_rd(2'd0, v); check("R10 wrapped to zero", v, 0);
    check("R10 no pulse on overflow", ok, 0);
    k = 0;
    for (int i = 1; i < 100; i++) begin @(negedge clk); if (pulse) begin k = i; break; end end
    check("R10 match resumes", k, 6);

    // R11: period shrunk mid-run
    reg_wr(2'd1, 8'd100);
    reg_wr(2'd0, 8'd0);
    reg_wr(2'd1, 8'd3);
    k = 0;
    for (int i = 1; i < 300; i++) begin @(negedge clk); if (pulse) begin k = i; break; end end
    check("R11 new period used at once", k, 3);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule